// File: doc/BRIEF.md
# Baseline Subtraction, Cross-Scan Smoothing and Windowed Peak Detection

This block sits behind a decimation filter in a scanning electrochemical sensing chain. Each scan delivers a burst of indexed samples while a timing-control line is high. Upstream logic builds an averaged baseline and supplies the baseline word for the index of each incoming sample. The block subtracts that word from the sample and saturates the difference to a signed 11-bit word. It then smooths the result per timestamp across consecutive scans and streams the smoothed value out together with its index.

A windowed peak search runs alongside the stream. It looks for the largest signed smoothed value among the timestamps picked by a start and a length parameter. At the falling edge of the timing-control line it latches that maximum into a held output, which stays valid through the whole next scan. A user clear input returns the block to its idle state. After a clear, the block needs a new baseline-ready indication and a new scan start before it processes data again.

Top module: `bgs_peak_top`

## Requirements
- R1: After reset, `sub_rdy`, `peak_val` and `diff_vld` are all 0.
- R2: `sub_rdy` rises one cycle after a rising edge of `tc` at which `base_ok` is 1 and `user_clr` is 0. It then stays 1 until `user_clr` is asserted. A rising edge of `tc` with `base_ok` at 0 leaves it at 0.
- R3: A sample (`smp_vld`) is accepted only when `sub_rdy` and `base_ok` are both 1. For each accepted sample, `diff_vld` pulses for one cycle exactly two clock edges later and carries the same index on `diff_idx`. Samples that are not accepted produce no output.
- R4: The difference is `smp_data - base_data`, saturated to the signed 11-bit range of -1024 to 1023.
- R5: `avg_sel` selects the smoothing depth. A value of 0 outputs the current difference. A value of 1 outputs (current + previous scan) >>> 1. A value of 2 or 3 outputs (current + three previous scans) >>> 2. All shifts are arithmetic, so results round toward minus infinity.
- R6: The history holds the saturated, unsmoothed differences of earlier scans for each timestamp. Reset and `user_clr` clear every history entry to 0.
- R7: `peak_val` is loaded in the cycle after `tc` is first seen low following a high period. The loaded value is the largest signed smoothed value of that scan whose index lies in `win_start` to `win_start+win_len-1`, with the window clipped at index 95. If no sample falls in the window, `peak_val` is loaded with 0.
- R8: `peak_val` changes only at the load of R7 or on `user_clr`, which sets it to 0. It holds across the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| user_clr | input | 1 | User clear: drops sub_rdy, clears history and peak |
| base_ok | input | 1 | Averaged baseline is ready |
| tc | input | 1 | Timing control, high during a scan |
| smp_vld | input | 1 | Sample valid |
| smp_idx | input | 7 | Sample timestamp index, 0..95 |
| smp_data | input | 14 | Signed decimated sample |
| base_data | input | 18 | Signed baseline word for smp_idx |
| avg_sel | input | 2 | Smoothing depth select |
| win_start | input | 7 | First index of the peak window |
| win_len | input | 7 | Number of indices in the peak window |
| diff_vld | output | 1 | Smoothed output valid |
| diff_idx | output | 7 | Index of the smoothed output |
| diff_val | output | 11 | Signed smoothed difference |
| sub_rdy | output | 1 | Subtraction active status |
| peak_val | output | 11 | Held signed peak of the last scan |

## Verification
A corrupted history entry does not show up in the scan where it happens. It appears in the next scan that reaches the same index, as a `diff_val` offset by a quarter or a half of the error, depending on the depth. This is why the stimulus reuses indices across scans and changes `avg_sel` between them. A fault in the window or in the latching logic shows up only on `peak_val`, one cycle after `tc` falls. So every scan ends with a check of `peak_val`, and one window deliberately excludes the larger values. A fault in the sticky status flag shows up as outputs that are missing or spurious within two cycles of a sample.

// File: rtl/bgs_pkg.sv
// Package: shared encodings for the baseline-subtraction / peak block.
// Assumes nothing beyond the two-bit smoothing select defined here.
package bgs_pkg;
    // Smoothing depth encodings (two codes map to the four-scan mean)
    typedef enum logic [1:0] {
        AVG_D1  = 2'd0,
        AVG_D2  = 2'd1,
        AVG_D4A = 2'd2,
        AVG_D4B = 2'd3
    } avg_sel_e;
endpackage

// File: rtl/bgs_diff.sv
// Module: bgs_diff
// Subtracts the baseline word from a sample and saturates the difference
// to a signed OUT_W word, registering the result with its index.
// Assumes i_base belongs to the same index as i_smp in the same cycle.
module bgs_diff #(
    parameter int DIN_W  = 14,
    parameter int BASE_W = 18,
    parameter int OUT_W  = 11,
    parameter int IDX_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    i_en,
    input  logic                    i_vld,
    input  logic [IDX_W-1:0]        i_idx,
    input  logic signed [DIN_W-1:0] i_smp,
    input  logic signed [BASE_W-1:0] i_base,
    output logic                    o_vld,
    output logic [IDX_W-1:0]        o_idx,
    output logic signed [OUT_W-1:0] o_val
);
    localparam int WID = ((DIN_W > BASE_W) ? DIN_W : BASE_W) + 1;
    localparam logic signed [WID-1:0] MAXV = WID'((1 <<< (OUT_W-1)) - 1);
    localparam logic signed [WID-1:0] MINV = -MAXV - WID'(1);

    logic signed [WID-1:0]   smp_x;
    logic signed [WID-1:0]   base_x;
    logic signed [WID-1:0]   diff;
    logic signed [OUT_W-1:0] sat;

    // Sign-extend, subtract and clamp to the narrow output range
    always_comb begin
        smp_x  = {{(WID-DIN_W){i_smp[DIN_W-1]}}, i_smp};
        base_x = {{(WID-BASE_W){i_base[BASE_W-1]}}, i_base};
        diff   = smp_x - base_x;
        if (diff > MAXV)
            sat = MAXV[OUT_W-1:0];
        else if (diff < MINV)
            sat = MINV[OUT_W-1:0];
        else
            sat = diff[OUT_W-1:0];
    end

    // Register accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            o_vld <= 1'b0;
            o_idx <= '0;
            o_val <= '0;
        end else begin
            o_vld <= i_vld && i_en;
            if (i_vld && i_en) begin
                o_idx <= i_idx;
                o_val <= sat;
            end
        end
    end
endmodule

// File: rtl/bgs_hist_avg.sv
// Module: bgs_hist_avg
// Keeps HIST rows of per-timestamp history of unsmoothed differences and
// outputs the mean of the current value with 0, 1 or 3 older scans.
// Assumes HIST >= 3 and one write per index per scan.
module bgs_hist_avg
    import bgs_pkg::*;
#(
    parameter int OUT_W = 11,
    parameter int IDX_W = 7,
    parameter int NTS   = 96,
    parameter int HIST  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [1:0]              sel,
    input  logic                    i_vld,
    input  logic [IDX_W-1:0]        i_idx,
    input  logic signed [OUT_W-1:0] i_val,
    output logic                    o_vld,
    output logic [IDX_W-1:0]        o_idx,
    output logic signed [OUT_W-1:0] o_val
);
    localparam int SW = OUT_W + 2;

    logic signed [OUT_W-1:0] mem [HIST][NTS];
    logic signed [OUT_W-1:0] rd  [HIST];
    logic                    idx_ok;
    logic signed [SW-1:0]    cur_x;
    logic signed [SW-1:0]    sum;
    logic signed [SW-1:0]    avg;

    assign idx_ok = (int'(i_idx) < NTS);

    // One read port per history row
    for (genvar d = 0; d < HIST; d++) begin : g_rd
        always_comb rd[d] = idx_ok ? mem[d][i_idx] : '0;
    end

    // Select depth and form the floor-rounded mean
    always_comb begin
        cur_x = {{2{i_val[OUT_W-1]}}, i_val};
        case (avg_sel_e'(sel))
            AVG_D1: begin
                sum = cur_x;
                avg = sum;
            end
            AVG_D2: begin
                sum = cur_x + {{2{rd[0][OUT_W-1]}}, rd[0]};
                avg = sum >>> 1;
            end
            default: begin
                sum = cur_x + {{2{rd[0][OUT_W-1]}}, rd[0]}
                            + {{2{rd[1][OUT_W-1]}}, rd[1]}
                            + {{2{rd[2][OUT_W-1]}}, rd[2]};
                avg = sum >>> 2;
            end
        endcase
    end

    // Shift history for the written index; clear all rows on reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int d = 0; d < HIST; d++)
                for (int e = 0; e < NTS; e++)
                    mem[d][e] <= '0;
        end else if (i_vld && idx_ok) begin
            for (int d = HIST-1; d > 0; d--)
                mem[d][i_idx] <= mem[d-1][i_idx];
            mem[0][i_idx] <= i_val;
        end
    end

    // Register the smoothed output
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            o_vld <= 1'b0;
            o_idx <= '0;
            o_val <= '0;
        end else begin
            o_vld <= i_vld;
            if (i_vld) begin
                o_idx <= i_idx;
                o_val <= avg[OUT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bgs_peak_win.sv
// Module: bgs_peak_win
// Tracks the largest signed value whose index lies in a window clipped at
// NTS-1, restarts at scan start and latches the result at scan end.
// Assumes scan_start and scan_end are single-cycle pulses.
module bgs_peak_win #(
    parameter int OUT_W = 11,
    parameter int IDX_W = 7,
    parameter int NTS   = 96
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    scan_start,
    input  logic                    scan_end,
    input  logic                    i_vld,
    input  logic [IDX_W-1:0]        i_idx,
    input  logic signed [OUT_W-1:0] i_val,
    input  logic [IDX_W-1:0]        win_start,
    input  logic [IDX_W-1:0]        win_len,
    output logic signed [OUT_W-1:0] peak
);
    logic [IDX_W:0]          win_end;
    logic                    in_win;
    logic                    take;
    logic                    have;
    logic                    have_n;
    logic signed [OUT_W-1:0] cur;
    logic signed [OUT_W-1:0] cur_n;

    // Window membership and running-maximum update
    always_comb begin
        win_end = {1'b0, win_start} + {1'b0, win_len};
        in_win  = i_vld && (i_idx >= win_start) && ({1'b0, i_idx} < win_end)
                  && (int'(i_idx) < NTS);
        take    = in_win && (!have || (i_val > cur));
        cur_n   = take ? i_val : cur;
        have_n  = have || in_win;
    end

    // Running maximum state and held peak
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have <= 1'b0;
            cur  <= '0;
            peak <= '0;
        end else begin
            have <= scan_start ? 1'b0 : have_n;
            cur  <= cur_n;
            if (scan_end)
                peak <= have_n ? cur_n : '0;
        end
    end
endmodule

// File: rtl/bgs_peak_top.sv
// Module: bgs_peak_top
// Baseline subtraction, cross-scan smoothing and windowed peak detection.
// Assumes the baseline word for smp_idx arrives in the same cycle and that
// all samples of a scan arrive while tc is high, ending two cycles before it falls.
module bgs_peak_top #(
    parameter int DIN_W  = 14,
    parameter int BASE_W = 18,
    parameter int OUT_W  = 11,
    parameter int IDX_W  = 7,
    parameter int NTS    = 96,
    parameter int HIST   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     user_clr,
    input  logic                     base_ok,
    input  logic                     tc,
    input  logic                     smp_vld,
    input  logic [IDX_W-1:0]         smp_idx,
    input  logic signed [DIN_W-1:0]  smp_data,
    input  logic signed [BASE_W-1:0] base_data,
    input  logic [1:0]               avg_sel,
    input  logic [IDX_W-1:0]         win_start,
    input  logic [IDX_W-1:0]         win_len,
    output logic                     diff_vld,
    output logic [IDX_W-1:0]         diff_idx,
    output logic signed [OUT_W-1:0]  diff_val,
    output logic                     sub_rdy,
    output logic signed [OUT_W-1:0]  peak_val
);
    logic                    tc_q;
    logic                    tc_rise;
    logic                    tc_fall;
    logic                    s1_vld;
    logic [IDX_W-1:0]        s1_idx;
    logic signed [OUT_W-1:0] s1_val;

    assign tc_rise = tc && !tc_q;
    assign tc_fall = !tc && tc_q;

    // Delay tc for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= tc;
    end

    // Sticky status: set at scan start with baseline ready, dropped by clear
    always_ff @(posedge clk) begin
        if (!rst_n || user_clr)     sub_rdy <= 1'b0;
        else if (tc_rise && base_ok) sub_rdy <= 1'b1;
    end

    bgs_diff #(
        .DIN_W(DIN_W), .BASE_W(BASE_W), .OUT_W(OUT_W), .IDX_W(IDX_W)
    ) u_diff (
        .clk(clk), .rst_n(rst_n), .clr(user_clr),
        .i_en(sub_rdy && base_ok),
        .i_vld(smp_vld), .i_idx(smp_idx), .i_smp(smp_data), .i_base(base_data),
        .o_vld(s1_vld), .o_idx(s1_idx), .o_val(s1_val)
    );

    bgs_hist_avg #(
        .OUT_W(OUT_W), .IDX_W(IDX_W), .NTS(NTS), .HIST(HIST)
    ) u_avg (
        .clk(clk), .rst_n(rst_n), .clr(user_clr), .sel(avg_sel),
        .i_vld(s1_vld), .i_idx(s1_idx), .i_val(s1_val),
        .o_vld(diff_vld), .o_idx(diff_idx), .o_val(diff_val)
    );

    bgs_peak_win #(
        .OUT_W(OUT_W), .IDX_W(IDX_W), .NTS(NTS)
    ) u_peak (
        .clk(clk), .rst_n(rst_n), .clr(user_clr),
        .scan_start(tc_rise), .scan_end(tc_fall),
        .i_vld(diff_vld), .i_idx(diff_idx), .i_val(diff_val),
        .win_start(win_start), .win_len(win_len),
        .peak(peak_val)
    );
endmodule

// File: rtl/bgs_peak_chk.sv
// Module: bgs_peak_chk
// Port-level temporal checks for bgs_peak_top, attached by bind.
module bgs_peak_chk #(
    parameter int IDX_W = 7,
    parameter int OUT_W = 11,
    parameter int NTS   = 96
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    user_clr,
    input logic                    base_ok,
    input logic                    tc,
    input logic                    diff_vld,
    input logic [IDX_W-1:0]        diff_idx,
    input logic                    sub_rdy,
    input logic signed [OUT_W-1:0] peak_val
);
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_rdy && !user_clr) |=> sub_rdy); // R2
    AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_rdy) |-> ($past(tc) && $past(base_ok) && !$past(user_clr))); // R2
    AST_OUT_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        diff_vld |-> $past(sub_rdy, 2)); // R3
    AST_OUT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        diff_vld |-> (int'(diff_idx) < NTS)); // R3
    AST_PEAK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(peak_val) |-> ($past(user_clr) || ($past(tc, 2) && !$past(tc)))); // R8
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(user_clr) |-> (!sub_rdy && peak_val == '0)); // R8
endmodule

bind bgs_peak_top bgs_peak_chk #(.IDX_W(IDX_W), .OUT_W(OUT_W), .NTS(NTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .user_clr(user_clr), .base_ok(base_ok), .tc(tc),
    .diff_vld(diff_vld), .diff_idx(diff_idx), .sub_rdy(sub_rdy), .peak_val(peak_val)
);

// File: tb/test_bgs_peak_top.sv
module test_bgs_peak_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              user_clr = 1'b0;
    logic              base_ok = 1'b0;
    logic              tc = 1'b0;
    logic              smp_vld = 1'b0;
    logic [6:0]        smp_idx = '0;
    logic signed [13:0] smp_data = '0;
    logic signed [17:0] base_data = '0;
    logic [1:0]        avg_sel = 2'd0;
    logic [6:0]        win_start = '0;
    logic [6:0]        win_len = '0;
    logic              diff_vld;
    logic [6:0]        diff_idx;
    logic signed [10:0] diff_val;
    logic              sub_rdy;
    logic signed [10:0] peak_val;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bgs_peak_top i_bgs_peak_top (.*);

    typedef struct packed {
        logic [6:0]         idx;
        logic signed [13:0] smp;
        logic signed [17:0] base;
        logic signed [10:0] exp;
    } vec_t;

    // Mode-0 subtraction and saturation vectors (R4)
    localparam vec_t VECS [8] = '{
        '{7'd10,  14'sd300,   18'sd100,   11'sd200},
        '{7'd11, -14'sd50,    18'sd25,   -11'sd75},
        '{7'd12,  14'sd8191, -18'sd1000,  11'sd1023},
        '{7'd13, -14'sd8192,  18'sd1000, -11'sd1024},
        '{7'd14,  14'sd1023,  18'sd0,     11'sd1023},
        '{7'd15, -14'sd1024,  18'sd0,    -11'sd1024},
        '{7'd16,  14'sd0,     18'sd1024, -11'sd1024},
        '{7'd17,  14'sd5,    -18'sd1018,  11'sd1023}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample, return the output seen two edges later
    task automatic send(input int idx, input int smp, input int base,
                        output bit vld, output int val, output int oidx);
        @(negedge clk);
        smp_vld = 1'b1; smp_idx = 7'(idx); smp_data = 14'(smp); base_data = 18'(base);
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
        vld = diff_vld; val = int'(diff_val); oidx = int'(diff_idx);
    endtask

    task automatic tc_up();
        @(negedge clk); tc = 1'b1;
        @(negedge clk);
    endtask

    task automatic tc_down();
        @(negedge clk); tc = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit v; int val; int oi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sub_rdy", int'(sub_rdy), 0);
        check("R1 peak_val", int'(peak_val), 0);
        check("R1 diff_vld", int'(diff_vld), 0);

        // Sample before any scan start: no output (R3)
        base_ok = 1'b1;
        send(3, 100, 0, v, val, oi);
        check("R3 not accepted before sub_rdy", int'(v), 0);

        // Scan 1: mode 0, window 10..11
        avg_sel = 2'd0; win_start = 7'd10; win_len = 7'd2;
        tc_up();
        check("R2 sub_rdy rises", int'(sub_rdy), 1);
        foreach (VECS[k]) begin
            send(int'(VECS[k].idx), int'(VECS[k].smp), int'(VECS[k].base), v, val, oi);
            check("R3 diff_vld", int'(v), 1);
            check("R3 diff_idx", oi, int'(VECS[k].idx));
            check("R4 diff_val", val, int'(VECS[k].exp));
        end
        tc_down();
        check("R7 window peak excludes idx12", int'(peak_val), 200);
        tc_up();
        check("R8 peak held into next scan", int'(peak_val), 200);

        // Scan 2: mode 1, window idx 11 only, negative peak
        avg_sel = 2'd1; win_start = 7'd11; win_len = 7'd1;
        send(10, 100, 0, v, val, oi);
        check("R5 two-scan mean", val, 150);
        send(11, -76, 0, v, val, oi);
        check("R5 floor rounding", val, -76);
        tc_down();
        check("R7 negative peak", int'(peak_val), -76);

        // Scan 3: mode 2, window clipped at 95
        avg_sel = 2'd2; win_start = 7'd90; win_len = 7'd100;
        tc_up();
        send(10, 40, 0, v, val, oi);
        check("R6 four-scan mean with history", val, 85);
        send(11, -80, 0, v, val, oi);
        check("R6 four-scan floor", val, -58);
        send(95, 7, 0, v, val, oi);
        check("R5 four-scan at fresh index", val, 1);
        tc_down();
        check("R7 clipped window peak", int'(peak_val), 1);

        // Scan 4: empty window
        avg_sel = 2'd0; win_start = 7'd100; win_len = 7'd5;
        tc_up();
        send(20, 50, 0, v, val, oi);
        tc_down();
        check("R7 empty window gives 0", int'(peak_val), 0);

        // User clear
        @(negedge clk); user_clr = 1'b1;
        @(negedge clk); user_clr = 1'b0;
        check("R2 sub_rdy cleared", int'(sub_rdy), 0);
        check("R8 peak cleared", int'(peak_val), 0);
        tc_down();

        // Scan start without baseline: stays idle
        base_ok = 1'b0;
        tc_up();
        check("R2 no rise without base_ok", int'(sub_rdy), 0);
        tc_down();

        // Scan start with baseline, history must be zero
        base_ok = 1'b1; avg_sel = 2'd1;
        tc_up();
        check("R2 rises after clear", int'(sub_rdy), 1);
        send(10, 60, 0, v, val, oi);
        check("R6 history cleared", val, 30);
        tc_down();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule